// File: doc/BRIEF.md
# Interrupt and DMA Priority Daisy-Chain

This block is the chain-facing part of a two-channel serial peripheral that shares an interrupt line and a DMA hold line with other devices. On the interrupt side it passes a priority token down the chain. The outgoing priority is active only when the incoming priority is active and this device has no interrupt of its own. It drives the shared open-drain interrupt line. It also follows the processor's acknowledge sequence of two or three pulses and, when it has won that sequence, places a programmed vector on the data bus during the final pulse.

On the DMA side it mirrors four internal transfer requests as active-high request outputs: receive and transmit for each of two channels. It passes the hold acknowledge on to the next device only when it has nothing pending. When the incoming hold acknowledge goes active, it grants exactly one DMA cycle to the highest-priority outstanding request.

All chain inputs are sampled on the system clock, and every output is registered. "Low" and "high" below refer to active-low (`_n`) chain signals.

Top module: `irq_dma_chain`

## Requirements
- R1: While reset is held, and in the first cycle after it: `int_n`, `pri_out_n` and `hao_n` are 1; `vec_oe`, `vec_data`, `dma_grant`, `dma_cycle` and `drq` are all 0.
- R2: Outside an acknowledge sequence, `pri_out_n` is 0 one cycle after a clock edge where `pri_in_n` = 0 and `irq_pend` = 0. Otherwise it is 1.
- R3: `int_n` is the inverse of `irq_pend` sampled at the previous clock edge. A 0 on `int_n` means the shared line is pulled low.
- R4: An acknowledge sequence starts on a sampled falling edge of `intack_n`. Its length is 3 pulses if `cfg_three_pulse` was 1 at that first falling edge, and 2 pulses otherwise. Changes to `cfg_three_pulse` later in the sequence have no effect. The sequence ends on the rising edge that closes the last pulse, and the next falling edge starts a new sequence.
- R5: The device responds to a sequence only if, at its first falling edge, `pri_in_n` = 0, `irq_pend` = 1 and `cfg_vec_en` = 1. When it responds, `vec_oe` = 1 and `vec_data` = `cfg_vector` for every cycle after an edge that sampled `intack_n` = 0 during the last pulse. At all other times `vec_oe` = 0 and `vec_data` = 0.
- R6: During an acknowledge sequence, `pri_out_n` uses the `irq_pend` value captured at the first falling edge instead of the live value. The live value is used again from the edge that ends the sequence.
- R7: `hao_n` is 0 one cycle after a clock edge where `hai_n` = 0 and all `dma_req` bits are 0. Otherwise it is 1.
- R8: On a sampled falling edge of `hai_n` with at least one `dma_req` bit set, `dma_grant` is one-hot for exactly one cycle, and `dma_cycle` is 1 in that same cycle. The bit chosen is the lowest set index in the fixed order bit 0 receive A, bit 1 transmit A, bit 2 receive B, bit 3 transmit B.
- R9: No grant is issued on a falling edge of `hai_n` when `dma_req` is all zero, or while `hai_n` stays low after its falling edge, whatever `dma_req` does.
- R10: `drq` equals `dma_req` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_three_pulse | input | 1 | 1: three-pulse acknowledge, 0: two-pulse |
| cfg_vec_en | input | 1 | Allow the vector to be driven |
| cfg_vector | input | 8 | Vector value |
| irq_pend | input | 1 | An internal interrupt request has been accepted |
| pri_in_n | input | 1 | Incoming interrupt priority, active low |
| pri_out_n | output | 1 | Outgoing interrupt priority, active low |
| int_n | output | 1 | Interrupt line pull-down (0 = pull low) |
| intack_n | input | 1 | Interrupt acknowledge pulse, active low |
| vec_oe | output | 1 | Vector bus drive enable |
| vec_data | output | 8 | Vector byte |
| dma_req | input | 4 | Internal DMA requests: rxA, txA, rxB, txB |
| drq | output | 4 | DMA request outputs, active high |
| hai_n | input | 1 | Incoming hold acknowledge, active low |
| hao_n | output | 1 | Outgoing hold acknowledge, active low |
| dma_grant | output | 4 | One-hot grant of the DMA cycle |
| dma_cycle | output | 1 | A DMA cycle is performed this cycle |

## Verification
Several rules are checked by the assertions on every cycle:
- the grant is one-hot, lasts a single cycle and only follows a sampled low `hai_n`;
- `hao_n` and `pri_out_n` go low only after their enabling inputs;
- `int_n` tracks the pending request;
- the vector bus is zero whenever it is not enabled.

Other behaviour can only be shown by the bench scenarios, where a behavioural model is compared against the outputs on every clock:
- pulse counting, with the mode captured at the first pulse;
- whether the device responds at all;
- `pri_out_n` held during a sequence;
- which request wins arbitration.

// File: rtl/irq_dma_chain_pkg.sv
package irq_dma_chain_pkg;

    localparam int ACK_CNT_W = 2;

    typedef enum logic [1:0] {
        REQ_RX_A = 2'd0,
        REQ_TX_A = 2'd1,
        REQ_RX_B = 2'd2,
        REQ_TX_B = 2'd3
    } dma_src_e;

    typedef struct packed {
        logic                 ack_prev;
        logic                 seq;
        logic [ACK_CNT_W-1:0] cnt;
        logic                 frozen_req;
        logic                 respond;
        logic                 three;
        logic                 pri_out_n;
        logic                 int_n;
        logic                 vec_oe;
    } irq_state_t;

    typedef struct packed {
        logic hai_prev;
        logic hao_n;
        logic cycle;
    } dma_state_t;

endpackage

// File: rtl/irq_ack_chain.sv
module irq_ack_chain
    import irq_dma_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_three_pulse,
    input  logic             cfg_vec_en,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic             irq_pend,
    input  logic             pri_in_n,
    input  logic             intack_n,
    output logic             pri_out_n,
    output logic             int_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_data
);

    localparam logic [ACK_CNT_W-1:0] LAST_TWO   = ACK_CNT_W'(2);
    localparam logic [ACK_CNT_W-1:0] LAST_THREE = ACK_CNT_W'(3);

    irq_state_t       st_d, st_q;
    logic [VEC_W-1:0] vec_d, vec_q;

    always_comb begin
        logic                 fall;
        logic                 rise;
        logic [ACK_CNT_W-1:0] last_q;
        logic [ACK_CNT_W-1:0] last_d;
        logic                 req_eff;

        st_d   = st_q;
        fall   = st_q.ack_prev & ~intack_n;
        rise   = ~st_q.ack_prev & intack_n;
        last_q = st_q.three ? LAST_THREE : LAST_TWO;

        if (fall) begin
            if (!st_q.seq) begin
                st_d.seq        = 1'b1;
                st_d.cnt        = ACK_CNT_W'(1);
                st_d.frozen_req = irq_pend;
                st_d.respond    = ~pri_in_n & irq_pend & cfg_vec_en;
                st_d.three      = cfg_three_pulse;
            end else begin
                st_d.cnt = st_q.cnt + ACK_CNT_W'(1);
            end
        end else if (rise && st_q.seq && st_q.cnt == last_q) begin
            st_d.seq     = 1'b0;
            st_d.cnt     = '0;
            st_d.respond = 1'b0;
        end

        last_d  = st_d.three ? LAST_THREE : LAST_TWO;
        req_eff = st_d.seq ? st_d.frozen_req : irq_pend;

        st_d.ack_prev  = intack_n;
        st_d.int_n     = ~irq_pend;
        st_d.pri_out_n = pri_in_n | req_eff;
        st_d.vec_oe    = st_d.respond & st_d.seq & (st_d.cnt == last_d) & ~intack_n;
        vec_d          = st_d.vec_oe ? cfg_vector : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ack_prev: 1'b1, seq: 1'b0, cnt: '0, frozen_req: 1'b0,
                      respond: 1'b0, three: 1'b0, pri_out_n: 1'b1,
                      int_n: 1'b1, vec_oe: 1'b0};
            vec_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
        end
    end

    assign pri_out_n = st_q.pri_out_n;
    assign int_n     = st_q.int_n;
    assign vec_oe    = st_q.vec_oe;
    assign vec_data  = vec_q;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign onehot[i]    = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

endmodule

// File: rtl/dma_hold_chain.sv
module dma_hold_chain
    import irq_dma_chain_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] dma_req,
    input  logic            hai_n,
    output logic [NREQ-1:0] drq,
    output logic            hao_n,
    output logic [NREQ-1:0] dma_grant,
    output logic            dma_cycle
);

    dma_state_t      st_d, st_q;
    logic [NREQ-1:0] grant_d, grant_q;
    logic [NREQ-1:0] drq_d, drq_q;
    logic [NREQ-1:0] winner;

    dma_prio_pick #(.N(NREQ)) u_pick (
        .req    (dma_req),
        .onehot (winner)
    );

    always_comb begin
        logic fall;
        logic any_req;

        st_d    = st_q;
        any_req = |dma_req;
        fall    = st_q.hai_prev & ~hai_n;

        st_d.hai_prev = hai_n;
        st_d.hao_n    = hai_n | any_req;
        st_d.cycle    = fall & any_req;
        grant_d       = (fall && any_req) ? winner : '0;
        drq_d         = dma_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '{hai_prev: 1'b1, hao_n: 1'b1, cycle: 1'b0};
            grant_q <= '0;
            drq_q   <= '0;
        end else begin
            st_q    <= st_d;
            grant_q <= grant_d;
            drq_q   <= drq_d;
        end
    end

    assign hao_n     = st_q.hao_n;
    assign dma_cycle = st_q.cycle;
    assign dma_grant = grant_q;
    assign drq       = drq_q;

endmodule

// File: rtl/irq_dma_chain.sv
module irq_dma_chain
    import irq_dma_chain_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int NREQ  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_three_pulse,
    input  logic             cfg_vec_en,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic             irq_pend,
    input  logic             pri_in_n,
    output logic             pri_out_n,
    output logic             int_n,
    input  logic             intack_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_data,
    input  logic [NREQ-1:0]  dma_req,
    output logic [NREQ-1:0]  drq,
    input  logic             hai_n,
    output logic             hao_n,
    output logic [NREQ-1:0]  dma_grant,
    output logic             dma_cycle
);

    irq_ack_chain #(.VEC_W(VEC_W)) u_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_three_pulse (cfg_three_pulse),
        .cfg_vec_en      (cfg_vec_en),
        .cfg_vector      (cfg_vector),
        .irq_pend        (irq_pend),
        .pri_in_n        (pri_in_n),
        .intack_n        (intack_n),
        .pri_out_n       (pri_out_n),
        .int_n           (int_n),
        .vec_oe          (vec_oe),
        .vec_data        (vec_data)
    );

    dma_hold_chain #(.NREQ(NREQ)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req   (dma_req),
        .hai_n     (hai_n),
        .drq       (drq),
        .hao_n     (hao_n),
        .dma_grant (dma_grant),
        .dma_cycle (dma_cycle)
    );

endmodule

// File: rtl/irq_dma_chain_chk.sv
module irq_dma_chain_chk #(
    parameter int VEC_W = 8,
    parameter int NREQ  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pend,
    input logic             pri_in_n,
    input logic             pri_out_n,
    input logic             int_n,
    input logic             intack_n,
    input logic             vec_oe,
    input logic [VEC_W-1:0] vec_data,
    input logic [NREQ-1:0]  dma_req,
    input logic [NREQ-1:0]  drq,
    input logic             hai_n,
    input logic             hao_n,
    input logic [NREQ-1:0]  dma_grant,
    input logic             dma_cycle
);

    p_prio_needs_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !pri_out_n |-> $past(!pri_in_n));

    p_int_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int_n == !$past(irq_pend)));

    p_vec_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && vec_oe |-> $past(!intack_n));

    p_vec_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_data == '0));

    p_hao_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !hao_n |-> $past(!hai_n && dma_req == '0));

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_grant) && (dma_cycle == (dma_grant != '0)));

    p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cycle |=> !dma_cycle);

    p_grant_after_hai_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && dma_cycle |-> $past(!hai_n));

    p_drq_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (drq == $past(dma_req)));

endmodule

bind irq_dma_chain irq_dma_chain_chk #(.VEC_W(VEC_W), .NREQ(NREQ)) u_chk (.*);

// File: tb/irq_dma_chain_tb.sv
module irq_dma_chain_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_three_pulse = 1'b0;
    logic       cfg_vec_en = 1'b0;
    logic [7:0] cfg_vector = 8'h00;
    logic       irq_pend = 1'b0;
    logic       pri_in_n = 1'b1;
    logic       intack_n = 1'b1;
    logic [3:0] dma_req = 4'h0;
    logic       hai_n = 1'b1;
    logic       pri_out_n, int_n, vec_oe, hao_n, dma_cycle;
    logic [7:0] vec_data;
    logic [3:0] drq, dma_grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural model state
    bit m_ack_prev = 1, m_in_seq = 0, m_frz = 0, m_resp = 0;
    int m_pulses = 0, m_len = 2;
    bit m_hai_prev = 1;
    bit e_pri_out_n = 1, e_int_n = 1, e_vec_oe = 0, e_hao_n = 1, e_cycle = 0;
    int e_vec = 0, e_grant = 0, e_drq = 0;

    always #2 clk = ~clk;

    irq_dma_chain u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_three_pulse(cfg_three_pulse),
        .cfg_vec_en(cfg_vec_en), .cfg_vector(cfg_vector), .irq_pend(irq_pend),
        .pri_in_n(pri_in_n), .pri_out_n(pri_out_n), .int_n(int_n),
        .intack_n(intack_n), .vec_oe(vec_oe), .vec_data(vec_data),
        .dma_req(dma_req), .drq(drq), .hai_n(hai_n), .hao_n(hao_n),
        .dma_grant(dma_grant), .dma_cycle(dma_cycle)
    );

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_ack_prev = 1; m_in_seq = 0; m_frz = 0; m_resp = 0; m_pulses = 0;
            m_hai_prev = 1;
            e_pri_out_n = 1; e_int_n = 1; e_vec_oe = 0; e_vec = 0;
            e_hao_n = 1; e_cycle = 0; e_grant = 0; e_drq = 0;
            return;
        end
        // interrupt acknowledge side
        if (m_ack_prev && !intack_n) begin
            if (!m_in_seq) begin
                m_in_seq = 1; m_pulses = 1; m_frz = irq_pend;
                m_resp = !pri_in_n && irq_pend && cfg_vec_en;
                m_len = cfg_three_pulse ? 3 : 2;
            end else m_pulses++;
        end else if (!m_ack_prev && intack_n && m_in_seq && m_pulses == m_len) begin
            m_in_seq = 0; m_pulses = 0; m_resp = 0;
        end
        m_ack_prev  = intack_n;
        e_int_n     = !irq_pend;
        e_pri_out_n = !(!pri_in_n && !(m_in_seq ? m_frz : irq_pend));
        e_vec_oe    = m_resp && m_in_seq && m_pulses == m_len && !intack_n;
        e_vec       = e_vec_oe ? int'(cfg_vector) : 0;
        // DMA side
        e_drq   = int'(dma_req);
        e_hao_n = !(!hai_n && dma_req == 0);
        e_grant = 0;
        if (m_hai_prev && !hai_n && dma_req != 0) begin
            for (int k = 3; k >= 0; k--) if (dma_req[k]) e_grant = 1 << k;
        end
        e_cycle    = (e_grant != 0);
        m_hai_prev = hai_n;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        chk("R2/R6 pri_out_n", int'(pri_out_n), int'(e_pri_out_n));
        chk("R3 int_n", int'(int_n), int'(e_int_n));
        chk("R5 vec_oe", int'(vec_oe), int'(e_vec_oe));
        chk("R5 vec_data", int'(vec_data), e_vec);
        chk("R7 hao_n", int'(hao_n), int'(e_hao_n));
        chk("R8 dma_grant", int'(dma_grant), e_grant);
        chk("R8 dma_cycle", int'(dma_cycle), int'(e_cycle));
        chk("R10 drq", int'(drq), e_drq);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ack_pulse(int lo, int hi);
        intack_n = 1'b0; steps(lo);
        intack_n = 1'b1; steps(hi);
    endtask

    initial begin
        #1;
        steps(3);
        // R1: reset state
        chk("R1 int_n", int'(int_n), 1);
        chk("R1 pri_out_n", int'(pri_out_n), 1);
        chk("R1 hao_n", int'(hao_n), 1);
        chk("R1 vec/grant/drq", int'({vec_oe, vec_data, dma_grant, dma_cycle, drq}), 0);
        rst_n = 1'b1;
        step();
        chk("R1 first cycle", int'({vec_oe, dma_grant, dma_cycle, drq}), 0);

        // R2 R3: chain propagation
        pri_in_n = 1'b0; steps(2);
        chk("R2 pass with no request", int'(pri_out_n), 0);
        irq_pend = 1'b1; steps(2);
        chk("R2 blocked by request", int'(pri_out_n), 1);
        chk("R3 line pulled", int'(int_n), 0);
        pri_in_n = 1'b1; irq_pend = 1'b0; steps(2);

        // R5 R6: two-pulse responding, request drops mid-sequence
        cfg_vector = 8'hA5; cfg_vec_en = 1'b1; cfg_three_pulse = 1'b0;
        pri_in_n = 1'b0; irq_pend = 1'b1; steps(2);
        ack_pulse(2, 2);
        irq_pend = 1'b0; steps(2);
        chk("R6 held during sequence", int'(pri_out_n), 1);
        intack_n = 1'b0; step();
        chk("R5 vector on last pulse", int'(vec_data), 'hA5);
        step(); intack_n = 1'b1; steps(2);
        chk("R6 released after sequence", int'(pri_out_n), 0);

        // R4: mode captured at first pulse; 3-pulse responding
        irq_pend = 1'b1; cfg_vector = 8'h3C; cfg_three_pulse = 1'b1; steps(2);
        ack_pulse(1, 2);
        cfg_three_pulse = 1'b0;
        ack_pulse(2, 2);
        chk("R4 no vector on pulse two of three", int'(vec_oe), 0);
        intack_n = 1'b0; step();
        chk("R4 vector on pulse three", int'(vec_oe), 1);
        intack_n = 1'b1; steps(2);
        // R4: new sequence after end
        ack_pulse(1, 1);
        intack_n = 1'b0; step();
        chk("R4 restart counts from one", int'(vec_oe), 1);
        intack_n = 1'b1; steps(2);

        // R5: not responding when priority-in inactive, or vector disabled
        pri_in_n = 1'b1; ack_pulse(1, 1); ack_pulse(2, 2);
        chk("R5 no vector without priority", int'(vec_oe), 0);
        pri_in_n = 1'b0; cfg_vec_en = 1'b0; ack_pulse(1, 1); ack_pulse(2, 2);
        chk("R5 no vector when disabled", int'(vec_oe), 0);
        irq_pend = 1'b0; cfg_vec_en = 1'b1;
        ack_pulse(1, 1); ack_pulse(2, 2);
        chk("R5 no vector without request", int'(vec_oe), 0);

        // R7 R8 R9 R10: DMA side
        dma_req = 4'b1100; steps(2);
        hai_n = 1'b0; step();
        chk("R8 rxB wins over txB", int'(dma_grant), 4);
        dma_req = 4'b0011; steps(3);
        chk("R9 no second grant while held", int'(dma_cycle), 0);
        dma_req = 4'b0000; steps(2);
        chk("R7 hold passed on", int'(hao_n), 0);
        hai_n = 1'b1; steps(2);
        hai_n = 1'b0; step();
        chk("R9 no grant without request", int'(dma_cycle), 0);
        hai_n = 1'b1; dma_req = 4'b1111; steps(2);
        hai_n = 1'b0; step();
        chk("R8 rxA highest", int'(dma_grant), 1);
        hai_n = 1'b1; dma_req = 4'b1010; steps(2);
        hai_n = 1'b0; step();
        chk("R8 txA over txB", int'(dma_grant), 2);
        hai_n = 1'b1; dma_req = 4'b1000; steps(2);
        hai_n = 1'b0; step();
        chk("R8 txB alone", int'(dma_grant), 8);
        hai_n = 1'b1; dma_req = 4'b0000; steps(3);
        chk("R10 drq cleared", int'(drq), 0);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        #3;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule